// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the software-facing register front end of a 24-pin interrupt router. Software sees two word addresses: an 8-bit selector at offset 0x00 and a 32-bit data window at offset 0x10. The selector picks what the window reaches. That can be the router's 4-bit identity, a read-only version word, an arbitration word that mirrors the identity, or one half of a 64-bit per-pin routing entry. Selector 0x10 + 2*n reaches the low half of entry n and 0x11 + 2*n reaches its high half.

The delivery logic of the router is a neighbour of this block and is not part of it. It reads the whole entry table from a flat output bus. It reports per-pin "awaiting end-of-interrupt" events (set and clear pulses) and a per-pin "delivery in progress" level, and these land in two status bits that software writes cannot alter. Every accepted entry write raises a one-cycle update pulse carrying the pin index. A separate pulse flags writes that flip the pin's mask bit, so the neighbour can react to masking and reprogramming.

Entry bit layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery-in-progress 12, polarity 13, awaiting-EOI 14, trigger mode 15 (0 = edge, 1 = level), mask 16, destination 63:56. All other bits are stored as written.

Top module: `intr_regwin`

## Requirements
- R1: A write to offset 0x00 keeps only bits 7:0 of the write data as the selector. A read of offset 0x00 returns the selector zero-extended to 32 bits.
- R2: With selector 0x01, a window read returns (pin count − 1) in bits 23:16 and the version code in bits 7:0, with all other bits 0 (0x00170011 by default). Window writes with this selector change nothing.
- R3: With selector 0x00, a window write stores write-data bits 27:24 as the identity. Window reads with selector 0x00 or 0x02 return the identity in bits 27:24 and zeros elsewhere. A window write with selector 0x02 is discarded.
- R4: For selectors of 0x10 and above, the entry index is (selector − 0x10) >> 1. Selector bit 0 set reaches entry bits 63:32 and clear reaches bits 31:0. A write replaces only that half.
- R5: A window read returns 0xFFFFFFFF for any selector in 0x03..0x0F and for any entry index of 24 or more. A window write with such a selector changes no state and raises no update pulse.
- R6: An entry write leaves bit 12 (delivery-in-progress) and bit 14 (awaiting-EOI) as they were, whatever the write data holds in those positions.
- R7: If an entry's trigger-mode bit 15 is 0 (edge) after a write to either half, bit 14 of that entry becomes 0, even if a set pulse arrives in the same cycle.
- R8: After reset, every entry reads 0x00010000 in its low half and 0 in its high half, and the selector and the identity are 0.
- R9: Reads of offsets other than 0x00 and 0x10 return 0. Writes to them change no state.
- R10: Each accepted entry write drives upd_pulse high for exactly the next cycle, with upd_idx equal to the entry index. mask_chg is high in that cycle only if bit 16 changed, and mask_state then gives its new value.
- R11: Entry bit 12 follows dlv_busy of its pin with one cycle of delay. For bit 14, a set pulse sets it and otherwise a clear pulse clears it, unless R7 applies.
- R12: Each read request produces rd_valid high in the following cycle with rd_data, and rd_data holds its value until the next read. rd_valid is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset (0x00 selector, 0x10 window) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| pend_set | input | 24 | Per-pin pulse: set awaiting-EOI bit |
| pend_clr | input | 24 | Per-pin pulse: clear awaiting-EOI bit |
| dlv_busy | input | 24 | Per-pin delivery-in-progress level |
| entry_tbl | output | 1536 | All entries, entry n at bits 64n+63:64n |
| upd_pulse | output | 1 | An entry was written |
| upd_idx | output | 5 | Index of the written entry |
| mask_chg | output | 1 | The write flipped the entry's mask bit |
| mask_state | output | 1 | New mask value of the written entry |

## Verification
The bench goes after the write-merge corners. If a write cleared the status bits from the data, a pin awaiting EOI would look serviced and a level interrupt could be delivered twice. If edge mode were not applied after the merge, a high-half write to an edge entry would leave a stale pending bit. The selector edges 0x03..0x0F, 0x3F/0x40 and out-of-range writes are also targeted: an off-by-one decode would corrupt entry 23 or pulse for a pin that does not exist. Mask-flip pulses are checked on both a flipping write and a same-value write, because a design that compared the wrong half would report changes that did not happen.

// File: rtl/intr_regwin_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the interrupt router register window.
// Assumes 8-bit byte offsets and 64-bit routing entries.
package intr_regwin_pkg;
    localparam int          ENT_W      = 64;
    localparam logic [7:0]  OFF_SEL    = 8'h00;
    localparam logic [7:0]  OFF_WIN    = 8'h10;
    localparam logic [7:0]  SEL_ID     = 8'h00;
    localparam logic [7:0]  SEL_VER    = 8'h01;
    localparam logic [7:0]  SEL_ARB    = 8'h02;
    localparam logic [7:0]  SEL_ENT0   = 8'h10;
    // entry field positions decoded by the delivery neighbour
    localparam int          F_BUSY     = 12;
    localparam int          F_PEND     = 14;
    localparam int          F_TRIG     = 15;
    localparam int          F_MASK     = 16;
    localparam int          ID_LO      = 24;
    localparam int          ID_W       = 4;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_ENT,
        K_BAD
    } win_kind_t;
endpackage

// File: rtl/intr_regwin_decode.sv
`timescale 1ns/1ps
// Module: selector decoder. Maps the 8-bit selector to a window target,
// an entry index and a half select. Assumes NPINS <= 120.
module intr_regwin_decode
    import intr_regwin_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDXW  = $clog2(NPINS)
) (
    input  logic [7:0]      sel,
    output win_kind_t       kind,
    output logic [IDXW-1:0] idx,
    output logic            hi_half
);
    localparam logic [6:0] NPINS_W = 7'(NPINS);

    logic [7:0] rel;
    logic [6:0] raw;

    // offset of the selector from the first entry and its word-pair index
    always_comb begin
        rel = sel - SEL_ENT0;
        raw = rel[7:1];
    end

    // classify the selector
    always_comb begin
        case (sel)
            SEL_ID:  kind = K_ID;
            SEL_VER: kind = K_VER;
            SEL_ARB: kind = K_ARB;
            default: kind = (sel >= SEL_ENT0 && raw < NPINS_W) ? K_ENT : K_BAD;
        endcase
    end

    assign idx     = raw[IDXW-1:0];
    assign hi_half = sel[0];
endmodule

// File: rtl/intr_regwin_entry.sv
`timescale 1ns/1ps
// Module: one 64-bit routing entry. Merges half writes, protects the two
// status bits, applies edge-mode clearing and the delivery-side status
// inputs. Assumes wr_lo and wr_hi are never both high.
module intr_regwin_entry
    import intr_regwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    input  logic             pend_set,
    input  logic             pend_clr,
    input  logic             busy,
    output logic [ENT_W-1:0] ent
);
    localparam logic [ENT_W-1:0] RST_VAL = ENT_W'(1) << F_MASK;

    logic [ENT_W-1:0] nxt;
    logic             wr_any;

    // next entry value: merged half, protected status, pending update
    always_comb begin
        wr_any = wr_lo | wr_hi;
        nxt    = ent;
        if (wr_lo) nxt[31:0]  = wdata;
        if (wr_hi) nxt[63:32] = wdata;
        nxt[F_BUSY] = busy;
        if (wr_any && !nxt[F_TRIG])
            nxt[F_PEND] = 1'b0;
        else if (pend_set)
            nxt[F_PEND] = 1'b1;
        else if (pend_clr)
            nxt[F_PEND] = 1'b0;
        else
            nxt[F_PEND] = ent[F_PEND];
    end

    // entry storage
    always_ff @(posedge clk) begin
        if (!rst_n) ent <= RST_VAL;
        else        ent <= nxt;
    end
endmodule

// File: rtl/intr_regwin.sv
`timescale 1ns/1ps
// Module: register window of a 24-pin interrupt router. Holds the selector,
// the identity and the routing table. Serves reads with one cycle of latency
// and pulses on entry writes. Assumes one access per cycle.
module intr_regwin
    import intr_regwin_pkg::*;
#(
    parameter int          NPINS    = 24,
    parameter logic [7:0]  VER_CODE = 8'h11,
    parameter int          IDXW     = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [7:0]             req_addr,
    input  logic [31:0]            req_wdata,
    output logic                   rd_valid,
    output logic [31:0]            rd_data,
    input  logic [NPINS-1:0]       pend_set,
    input  logic [NPINS-1:0]       pend_clr,
    input  logic [NPINS-1:0]       dlv_busy,
    output logic [NPINS*ENT_W-1:0] entry_tbl,
    output logic                   upd_pulse,
    output logic [IDXW-1:0]        upd_idx,
    output logic                   mask_chg,
    output logic                   mask_state
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

    logic [7:0]       sel_q;
    logic [ID_W-1:0]  id_q;
    win_kind_t        kind;
    logic [IDXW-1:0]  idx;
    logic             hi_half;
    logic             wr_sel, wr_win, rd_req, ent_wr;
    logic [31:0]      win_rd;
    logic [ENT_W-1:0] ent_arr [NPINS];
    logic [NPINS-1:0] mask_vec;

    intr_regwin_decode #(.NPINS(NPINS), .IDXW(IDXW)) u_dec (
        .sel     (sel_q),
        .kind    (kind),
        .idx     (idx),
        .hi_half (hi_half)
    );

    // access qualification
    always_comb begin
        wr_sel = req_valid && req_write && (req_addr == OFF_SEL);
        wr_win = req_valid && req_write && (req_addr == OFF_WIN);
        rd_req = req_valid && !req_write;
        ent_wr = wr_win && (kind == K_ENT);
    end

    // selector register, low byte only
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 8'h00;
        else if (wr_sel) sel_q <= req_wdata[7:0];
    end

    // identity register, written only through selector 0
    always_ff @(posedge clk) begin
        if (!rst_n)                     id_q <= '0;
        else if (wr_win && kind == K_ID) id_q <= req_wdata[ID_LO +: ID_W];
    end

    // one storage slice per pin
    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        intr_regwin_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (ent_wr && !hi_half && (idx == IDXW'(g))),
            .wr_hi    (ent_wr &&  hi_half && (idx == IDXW'(g))),
            .wdata    (req_wdata),
            .pend_set (pend_set[g]),
            .pend_clr (pend_clr[g]),
            .busy     (dlv_busy[g]),
            .ent      (ent_arr[g])
        );
        assign entry_tbl[g*ENT_W +: ENT_W] = ent_arr[g];
        assign mask_vec[g] = ent_arr[g][F_MASK];
    end

    // window read multiplexer
    always_comb begin
        case (kind)
            K_ID, K_ARB: win_rd = 32'(id_q) << ID_LO;
            K_VER:       win_rd = VER_WORD;
            K_ENT:       win_rd = hi_half ? ent_arr[idx][63:32] : ent_arr[idx][31:0];
            default:     win_rd = '1;
        endcase
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                if (req_addr == OFF_SEL)      rd_data <= {24'h0, sel_q};
                else if (req_addr == OFF_WIN) rd_data <= win_rd;
                else                          rd_data <= '0;
            end
        end
    end

    // entry update and mask-flip notification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pulse  <= 1'b0;
            upd_idx    <= '0;
            mask_chg   <= 1'b0;
            mask_state <= 1'b0;
        end else begin
            upd_pulse <= ent_wr;
            mask_chg  <= ent_wr && !hi_half && (req_wdata[F_MASK] != mask_vec[idx]);
            if (ent_wr) begin
                upd_idx    <= idx;
                mask_state <= hi_half ? mask_vec[idx] : req_wdata[F_MASK];
            end
        end
    end
endmodule

// File: rtl/intr_regwin_chk.sv
`timescale 1ns/1ps
// Module: property checker for intr_regwin, attached by bind. Observes
// ports only.
module intr_regwin_chk
    import intr_regwin_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDXW  = $clog2(NPINS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic                   rd_valid,
    input logic [NPINS-1:0]       dlv_busy,
    input logic [NPINS*ENT_W-1:0] entry_tbl,
    input logic                   upd_pulse,
    input logic [IDXW-1:0]        upd_idx,
    input logic                   mask_chg,
    input logic                   mask_state
);
    logic [NPINS-1:0] mask_v, busy_v, pend_v, trig_v;

    // field slices of every entry
    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            mask_v[p] = entry_tbl[p*ENT_W + F_MASK];
            busy_v[p] = entry_tbl[p*ENT_W + F_BUSY];
            pend_v[p] = entry_tbl[p*ENT_W + F_PEND];
            trig_v[p] = entry_tbl[p*ENT_W + F_TRIG];
        end
    end

    assert_reset_mask_R8: assert property (@(posedge clk)
        !rst_n |=> (mask_v == '1));

    assert_busy_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (busy_v == $past(dlv_busy)));

    assert_edge_clears_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !trig_v[upd_idx]) |-> !pend_v[upd_idx]);

    assert_mask_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg |-> (upd_pulse && (mask_state == mask_v[upd_idx])
                      && ((mask_v ^ $past(mask_v)) == (NPINS'(1) << upd_idx))));

    assert_read_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);
endmodule

bind intr_regwin intr_regwin_chk #(.NPINS(NPINS), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rd_valid   (rd_valid),
    .dlv_busy   (dlv_busy),
    .entry_tbl  (entry_tbl),
    .upd_pulse  (upd_pulse),
    .upd_idx    (upd_idx),
    .mask_chg   (mask_chg),
    .mask_state (mask_state)
);

// File: tb/intr_regwin_tb.sv
`timescale 1ns/1ps
// Bench: directed accesses with literal expectations, plus a behavioural
// reference model compared on every clock.
module intr_regwin_tb;
    localparam int NP = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]      req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic [NP-1:0]   pend_set = '0, pend_clr = '0, dlv_busy = '0;
    logic [NP*64-1:0] entry_tbl;
    logic            upd_pulse, mask_chg, mask_state;
    logic [4:0]      upd_idx;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    intr_regwin u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .pend_set(pend_set), .pend_clr(pend_clr),
        .dlv_busy(dlv_busy), .entry_tbl(entry_tbl), .upd_pulse(upd_pulse),
        .upd_idx(upd_idx), .mask_chg(mask_chg), .mask_state(mask_state)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [63:0] m_ent [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    bit          e_rv, e_upd, e_mchg, e_mst;
    logic [31:0] e_rd;
    int          e_idx;
    bit          run_cmp = 0;

    function automatic logic [31:0] m_win();
        int ix;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return 32'h0000_0000 | ((NP - 1) << 16) | 32'h11;
        if (m_sel < 8'h10) return 32'hFFFF_FFFF;
        ix = (m_sel - 16) / 2;
        if (ix >= NP) return 32'hFFFF_FFFF;
        return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    endfunction

    // model update at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) m_ent[p] = 64'h1_0000;
            m_sel = 0; m_id = 0; e_rv = 0; e_rd = 0; e_upd = 0; e_mchg = 0;
        end else begin
            int wr_ix;
            wr_ix = -1;
            e_rv = req_valid && !req_write;
            e_upd = 0; e_mchg = 0;
            if (e_rv) e_rd = (req_addr == 8'h00) ? {24'h0, m_sel} :
                             (req_addr == 8'h10) ? m_win() : 32'h0;
            if (req_valid && req_write) begin
                if (req_addr == 8'h00) m_sel = req_wdata[7:0];
                else if (req_addr == 8'h10) begin
                    if (m_sel == 8'h00) m_id = req_wdata[27:24];
                    else if (m_sel >= 8'h10 && (m_sel - 16) / 2 < NP) begin
                        logic [63:0] o, nv;
                        wr_ix = (m_sel - 16) / 2;
                        o = m_ent[wr_ix];
                        nv = m_sel[0] ? {req_wdata, o[31:0]} : {o[63:32], req_wdata};
                        nv[12] = o[12]; nv[14] = o[14];
                        m_ent[wr_ix] = nv;
                        e_upd = 1; e_idx = wr_ix;
                        e_mchg = nv[16] != o[16]; e_mst = nv[16];
                    end
                end
            end
            for (int p = 0; p < NP; p++) begin
                m_ent[p][12] = dlv_busy[p];
                if (p == wr_ix && !m_ent[p][15]) m_ent[p][14] = 0;
                else if (pend_set[p]) m_ent[p][14] = 1;
                else if (pend_clr[p]) m_ent[p][14] = 0;
            end
        end
    end

    // compare against the model on every clock
    always @(negedge clk) begin
        if (run_cmp) begin
            logic [NP*64-1:0] etbl;
            for (int p = 0; p < NP; p++) etbl[p*64 +: 64] = m_ent[p];
            chk(rd_valid == e_rv, "R12 rd_valid", 64'(rd_valid), 64'(e_rv));
            if (e_rv) chk(rd_data == e_rd, "R12 rd_data vs model", 64'(rd_data), 64'(e_rd));
            chk(upd_pulse == e_upd, "R10 upd_pulse", 64'(upd_pulse), 64'(e_upd));
            if (e_upd) begin
                chk(upd_idx == 5'(e_idx), "R10 upd_idx", 64'(upd_idx), 64'(e_idx));
                chk(mask_chg == e_mchg, "R10 mask_chg", 64'(mask_chg), 64'(e_mchg));
                if (e_mchg) chk(mask_state == e_mst, "R10 mask_state", 64'(mask_state), 64'(e_mst));
            end
            if (entry_tbl != etbl) begin
                for (int p = 0; p < NP; p++)
                    if (entry_tbl[p*64 +: 64] != etbl[p*64 +: 64])
                        chk(0, "R6/R11 entry table", entry_tbl[p*64 +: 64], etbl[p*64 +: 64]);
            end else chk(1, "R6 entry table", 0, 0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk(rd_data == exp, tag, 64'(rd_data), 64'(exp));
    endtask

    task automatic rd_win(input logic [7:0] s, input logic [31:0] exp, input string tag);
        wr(8'h00, {24'h0, s});
        rd(8'h10, exp, tag);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        run_cmp = 1;
        // R8 reset state
        rd(8'h00, 32'h0, "R8 selector after reset");
        rd(8'h10, 32'h0, "R8 identity after reset");
        rd_win(8'h10, 32'h0001_0000, "R8 entry0 low after reset");
        rd_win(8'h3F, 32'h0, "R8 entry23 high after reset");
        // R1 selector keeps the low byte
        wr(8'h00, 32'hABCD_1201);
        rd(8'h00, 32'h0000_0001, "R1 selector low byte");
        // R2 version
        rd(8'h10, 32'h0017_0011, "R2 version word");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0017_0011, "R2 version after write");
        // R3 identity and arbitration
        rd_win(8'h00, 32'h0, "R3 identity still zero");
        wr(8'h10, 32'h5A00_0000);
        rd(8'h10, 32'h0A00_0000, "R3 identity written");
        rd_win(8'h02, 32'h0A00_0000, "R3 arbitration mirrors identity");
        wr(8'h10, 32'h0300_0000);
        rd(8'h10, 32'h0A00_0000, "R3 arbitration write discarded");
        // R4 half addressing on entry 5
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h0000_8031);
        rd(8'h10, 32'h0000_8031, "R4 entry5 low");
        wr(8'h00, 32'h1B);
        wr(8'h10, 32'h7E00_0000);
        rd(8'h10, 32'h7E00_0000, "R4 entry5 high");
        rd_win(8'h1A, 32'h0000_8031, "R4 low untouched by high write");
        // R11 status inputs
        @(negedge clk); pend_set[5] = 1; dlv_busy[5] = 1;
        @(negedge clk); pend_set[5] = 0;
        rd(8'h10, 32'h0000_D031, "R11 pending and busy set");
        // R6 protected bits, level mode
        wr(8'h10, 32'h0000_8032);
        rd(8'h10, 32'h0000_D032, "R6 status bits kept on write");
        // R7 edge mode clears pending
        wr(8'h10, 32'h0000_5033);
        rd(8'h10, 32'h0000_1033, "R7 edge write clears pending");
        @(negedge clk); pend_set[5] = 1;
        @(negedge clk); pend_set[5] = 0;
        rd(8'h10, 32'h0000_5033, "R11 set pulse on edge entry");
        wr(8'h00, 32'h1B);
        wr(8'h10, 32'h1100_0000);
        rd_win(8'h1A, 32'h0000_1033, "R7 high write on edge entry clears pending");
        @(negedge clk); pend_clr[5] = 1; dlv_busy[5] = 0;
        @(negedge clk); pend_clr[5] = 0;
        // R5 out of range
        rd_win(8'h40, 32'hFFFF_FFFF, "R5 index 24 reads ones");
        wr(8'h10, 32'h0);
        rd_win(8'h3E, 32'h0001_0000, "R5 entry23 untouched");
        rd_win(8'h05, 32'hFFFF_FFFF, "R5 reserved selector reads ones");
        // R9 other offsets
        rd(8'h04, 32'h0, "R9 offset 0x04 reads zero");
        rd(8'h20, 32'h0, "R9 offset 0x20 reads zero");
        wr(8'h20, 32'h12);
        rd(8'h00, 32'h05, "R9 stray write ignored");
        // R10 mask flip and same-value write
        wr(8'h00, 32'h3E);
        wr(8'h10, 32'h0);
        wr(8'h10, 32'h0);
        wr(8'h10, 32'h0001_0000);
        // random phase against the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            req_valid = $urandom_range(0, 3) != 0;
            req_write = $urandom_range(0, 1) == 1;
            case ($urandom_range(0, 4))
                0: begin req_addr = 8'h00; req_wdata = $urandom_range(0, 8'h45); end
                1: begin req_addr = $urandom_range(0, 255); req_wdata = $urandom; end
                default: begin req_addr = 8'h10; req_wdata = $urandom; end
            endcase
            pend_set = $urandom & $urandom;
            pend_clr = $urandom & $urandom;
            dlv_busy = $urandom;
        end
        @(negedge clk);
        req_valid = 0; pend_set = 0; pend_clr = 0;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule